// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block buffers the characters that a UART receiver assembles and hands them to a host read port. Each entry carries the eight data bits together with three per-character error flags: parity error, framing error and break. The host can read the number of queued characters at any time. An interrupt request is raised once that number reaches a threshold, and the host may set the threshold to any value. A live status bit says whether any character still in the queue carries an error.

Characters come in one per `wrValid` pulse from the receiver shift logic. The host reads the oldest entry from `rdData` and its flag outputs, and pulses `rdStrobe` to remove it. When the receiver is disabled, incoming characters are dropped. A character that arrives while the queue is full is lost, and the loss is recorded in a sticky overrun flag that stays set until the host reads status. A synchronous flush empties the queue in one cycle.

Top module: `rx_err_fifo`

## Requirements
- R1: The queue holds 128 entries. After 128 accepted writes with no reads, `fillLevel` reads 128 and every entry comes back intact.
- R2: `fillLevel` changes one cycle after the clock edge that samples a push or a pop. A push and a pop in the same cycle leave it unchanged.
- R3: Entries leave in arrival order. The oldest entry is shown on `rdData`, `rdParErr`, `rdFrmErr` and `rdBrk` while the queue is not empty, with each flag exactly as it was written.
- R4: `trigIrq` is high exactly while `fillLevel` is greater than or equal to `trigLevel`. A `trigLevel` of 0 acts as 1, so 127 distinct thresholds (1 to 127) exist.
- R5: `dataErr` is high exactly while at least one queued entry has any of its three error flags set. It updates together with `fillLevel`.
- R6: While `rxEnable` is low, `wrValid` stores nothing and does not set the overrun flag.
- R7: A write while the queue is full, with no pop in the same cycle, is discarded and sets `overrun` on the next cycle. `overrun` stays high until a `statusRead` pulse clears it. If a new overrun and `statusRead` fall in the same cycle, `overrun` stays set. When the queue is full, a write together with a pop is accepted.
- R8: A `flush` pulse makes `fillLevel` 0 and `dataErr` 0 on the next cycle. A write or read in the same cycle is ignored. `overrun` is left unchanged.
- R9: A read pulse while the queue is empty is ignored and `fillLevel` stays 0.
- R10: After reset, `fillLevel` is 0 and `trigIrq`, `dataErr` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable; when low, writes are dropped |
| flush | input | 1 | Synchronous queue clear |
| wrValid | input | 1 | Receiver delivers one character this cycle |
| wrData | input | 8 | Character data |
| wrParErr | input | 1 | Parity error flag of the incoming character |
| wrFrmErr | input | 1 | Framing error flag of the incoming character |
| wrBrk | input | 1 | Break flag of the incoming character |
| rdStrobe | input | 1 | Host removes the oldest entry |
| statusRead | input | 1 | Host status read; clears the overrun flag |
| trigLevel | input | 7 | Interrupt threshold (0 is treated as 1) |
| rdData | output | 8 | Data of the oldest entry |
| rdParErr | output | 1 | Parity flag of the oldest entry |
| rdFrmErr | output | 1 | Framing flag of the oldest entry |
| rdBrk | output | 1 | Break flag of the oldest entry |
| fillLevel | output | 8 | Number of queued entries, 0 to 128 |
| trigIrq | output | 1 | Level is at or above the threshold |
| dataErr | output | 1 | At least one queued entry is errored |
| overrun | output | 1 | Sticky flag: a character was lost |

## Verification
The head entry is combinational, so the bench compares it with the scoreboard front in the same cycle as the read pulse, before the edge that consumes it. `fillLevel`, `dataErr` and `overrun` are registered and change at the edge that samples the stimulus. `trigIrq` is derived combinationally from the registered level, so it changes at the same edge. Inputs are driven on the falling edge and held across one rising edge. All results are then sampled on the next falling edge, which is the first point at which each registered result is valid.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frmErr;
    logic              parErr;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoStrobe_t;

  function automatic logic entryBad(input rxEntry_t e);
    return e.brk | e.frmErr | e.parErr;
  endfunction
endpackage

// File: rtl/rx_err_fifo_dp.sv
module rx_err_fifo_dp
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  rxEntry_t         wrEntry,
  output rxEntry_t         headEntry,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             anyBad
);
  rxEntry_t         mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]  count, badCount;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      badCount <= '0;
    end else if (strobe.clear) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      badCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({strobe.push && entryBad(wrEntry), strobe.pop && entryBad(headEntry)})
        2'b10:   badCount <= badCount + 1'b1;
        2'b01:   badCount <= badCount - 1'b1;
        default: badCount <= badCount;
      endcase
    end
  end

  assign headEntry = mem[rdPtr];
  assign level     = count;
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign anyBad    = (badCount != '0);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop && !strobe.clear) |=> (count == $past(count) + 1'b1));
  assert_pop_shrinks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.push && !strobe.clear) |=> (count == $past(count) - 1'b1));
  assert_bad_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    badCount <= count);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0 && badCount == '0));
endmodule

// File: rtl/rx_err_fifo_ctl.sv
module rx_err_fifo_ctl
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              flush,
  input  logic              wrValid,
  input  logic              rdStrobe,
  input  logic              statusRead,
  input  logic [ADDR_W-1:0] trigLevel,
  input  logic [CNT_W-1:0]  level,
  input  logic              full,
  input  logic              empty,
  output fifoStrobe_t       strobe,
  output logic              trigIrq,
  output logic              overrun
);
  logic wrAttempt, lostChar;
  logic [CNT_W-1:0] effThr;

  always_comb begin
    wrAttempt    = wrValid && rxEnable && !flush;
    strobe.clear = flush;
    strobe.pop   = rdStrobe && !empty && !flush;
    strobe.push  = wrAttempt && (!full || strobe.pop);
    lostChar     = wrAttempt && full && !strobe.pop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           overrun <= 1'b0;
    else if (lostChar)   overrun <= 1'b1;
    else if (statusRead) overrun <= 1'b0;
  end

  assign effThr  = (trigLevel == '0) ? CNT_W'(1) : {1'b0, trigLevel};
  assign trigIrq = (level >= effThr);

  assert_disabled_no_store_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !rdStrobe && !flush) |=> (level == $past(level)));
  assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && rxEnable && !flush && full && !rdStrobe) |=> overrun);
  assert_overrun_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !wrValid) |=> !overrun);
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !wrValid) |=> empty);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              flush,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrParErr,
  input  logic              wrFrmErr,
  input  logic              wrBrk,
  input  logic              rdStrobe,
  input  logic              statusRead,
  input  logic [ADDR_W-1:0] trigLevel,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParErr,
  output logic              rdFrmErr,
  output logic              rdBrk,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              trigIrq,
  output logic              dataErr,
  output logic              overrun
);
  fifoStrobe_t strobe;
  rxEntry_t    wrEntry, headEntry;
  logic        full, empty;

  assign wrEntry = '{brk: wrBrk, frmErr: wrFrmErr, parErr: wrParErr, data: wrData};

  rx_err_fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .flush(flush),
    .wrValid(wrValid), .rdStrobe(rdStrobe), .statusRead(statusRead),
    .trigLevel(trigLevel), .level(fillLevel), .full(full), .empty(empty),
    .strobe(strobe), .trigIrq(trigIrq), .overrun(overrun)
  );

  rx_err_fifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEntry(wrEntry),
    .headEntry(headEntry), .level(fillLevel), .full(full), .empty(empty),
    .anyBad(dataErr)
  );

  assign rdData   = headEntry.data;
  assign rdParErr = headEntry.parErr;
  assign rdFrmErr = headEntry.frmErr;
  assign rdBrk    = headEntry.brk;
endmodule

// File: tb/rx_err_fifo_tb.sv
module rx_err_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxEnable = 1'b1, flush = 1'b0, wrValid = 1'b0, rdStrobe = 1'b0, statusRead = 1'b0;
  logic [7:0] wrData = '0;
  logic wrParErr = 1'b0, wrFrmErr = 1'b0, wrBrk = 1'b0;
  logic [6:0] trigLevel = 7'd0;
  logic [7:0] rdData, fillLevel;
  logic rdParErr, rdFrmErr, rdBrk, trigIrq, dataErr, overrun;

  int checks = 0, fails = 0;
  logic [10:0] sb[$];
  logic modelOvr = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_fifo u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .flush(flush), .wrValid(wrValid),
    .wrData(wrData), .wrParErr(wrParErr), .wrFrmErr(wrFrmErr), .wrBrk(wrBrk),
    .rdStrobe(rdStrobe), .statusRead(statusRead), .trigLevel(trigLevel),
    .rdData(rdData), .rdParErr(rdParErr), .rdFrmErr(rdFrmErr), .rdBrk(rdBrk),
    .fillLevel(fillLevel), .trigIrq(trigIrq), .dataErr(dataErr), .overrun(overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit modelBad();
    foreach (sb[i]) if (sb[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  // Monitor: registered results sampled one falling edge after the stimulus edge.
  task automatic monitor();
    int thr = (trigLevel == 0) ? 1 : int'(trigLevel);
    check(fillLevel == 8'(sb.size()), "R2 level", fillLevel, sb.size());
    check(dataErr == modelBad(), "R5 dataErr", dataErr, modelBad());
    check(overrun == modelOvr, "R7 overrun", overrun, modelOvr);
    check(trigIrq == (sb.size() >= thr), "R4 trigIrq", trigIrq, sb.size() >= thr);
  endtask

  // Driver: applies one cycle of stimulus and updates the scoreboard.
  task automatic step(input bit w, input logic [10:0] e, input bit r, input bit f, input bit s);
    bit popped = 1'b0, lost = 1'b0;
    wrValid = w; {wrBrk, wrFrmErr, wrParErr, wrData} = e;
    rdStrobe = r; flush = f; statusRead = s;
    if (r && !f && sb.size() > 0)
      check({rdBrk, rdFrmErr, rdParErr, rdData} == sb[0], "R3 head", {rdBrk, rdFrmErr, rdParErr, rdData}, sb[0]);
    if (f) sb.delete();
    else begin
      if (r && sb.size() > 0) begin void'(sb.pop_front()); popped = 1'b1; end
      if (w && rxEnable) begin
        if (sb.size() < DEPTH) sb.push_back(e);
        else lost = 1'b1;
      end
    end
    if (lost) modelOvr = 1'b1;
    else if (s) modelOvr = 1'b0;
    @(negedge clk);
    wrValid = 1'b0; rdStrobe = 1'b0; flush = 1'b0; statusRead = 1'b0;
    monitor();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(fillLevel == 0 && !trigIrq && !dataErr && !overrun, "R10 reset", fillLevel, 0);
    rstN = 1'b1;
    @(negedge clk);
    monitor();

    // R4: threshold 0 acts as 1
    trigLevel = 7'd0; monitor();
    step(1, 11'h041, 0, 0, 0);
    // R5: errored entries (parity, framing, break)
    step(1, 11'h142, 0, 0, 0);
    step(1, 11'h243, 0, 0, 0);
    step(1, 11'h444, 0, 0, 0);
    step(1, 11'h055, 0, 0, 0);
    trigLevel = 7'd5; #1; monitor();
    trigLevel = 7'd6; #1; monitor();
    // R3 / R5: drain in order, dataErr drops after last errored read
    for (int i = 0; i < 5; i++) step(0, '0, 1, 0, 0);
    // R9: read on empty
    step(0, '0, 1, 0, 0);
    check(fillLevel == 0, "R9 empty read", fillLevel, 0);

    // R1: fill to 128, errored entry first
    trigLevel = 7'd127;
    for (int i = 0; i < DEPTH; i++) step(1, {(i == 0) ? 3'b010 : 3'b000, 8'(i)}, 0, 0, 0);
    check(fillLevel == 8'd128, "R1 full", fillLevel, 128);
    // R7: overrun, discarded char
    step(1, 11'h0EE, 0, 0, 0);
    check(overrun == 1'b1, "R7 set", overrun, 1);
    step(1, 11'h0EF, 0, 0, 1); // new overrun wins over clear
    step(0, '0, 0, 0, 1);      // clears
    check(overrun == 1'b0, "R7 clear", overrun, 0);
    // R7: write with pop when full is accepted
    step(1, 11'h0AB, 1, 0, 0);
    // R6: disabled receiver
    rxEnable = 1'b0;
    step(0, '0, 1, 0, 0);
    step(1, 11'h7FF, 0, 0, 0);
    check(fillLevel == 8'd127 && !overrun, "R6 disabled", fillLevel, 127);
    rxEnable = 1'b1;
    // R1 / R3: drain all
    while (sb.size() > 0) step(0, '0, 1, 0, 0);

    // R2: simultaneous push/pop
    step(1, 11'h011, 0, 0, 0);
    step(1, 11'h112, 1, 0, 0);
    step(1, 11'h013, 1, 0, 0);
    check(fillLevel == 8'd1, "R2 push+pop", fillLevel, 1);

    // R8: flush with concurrent write
    step(1, 11'h214, 0, 0, 0);
    step(1, 11'h015, 0, 1, 0);
    check(fillLevel == 0 && !dataErr, "R8 flush", fillLevel, 0);
    step(1, 11'h016, 0, 0, 0);
    step(0, '0, 1, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule